// File: doc/BRIEF.md
# Multi-Width Integer ALU with Status-Word Flags

This block is the integer execution stage of a small processor core. It runs one logic, shift or add/subtract style operation on an operand pair, at a byte, word or doubleword width picked per operation. Two-operand forms combine a destination operand with a source operand and return the new destination value. Single-operand forms work on the destination alone. The block also returns a fresh 32-bit status word. In that word the carry, parity, auxiliary-carry, zero, sign and overflow flags sit at fixed bit positions. Every other bit comes from the incoming status word, apart from three bits whose values are fixed.

The operation is computed combinationally and registered once. An operation presented with `inValid` high in one cycle shows its result, destination write enable and new status word on the outputs after the next rising clock edge, with `outValid` high. A compare only updates the status word and never asks for a destination write.

Top module: `alu_top`

## Requirements
- R1: Opcodes 0 to 3 are the bitwise forms: 0 gives dst AND src, 1 gives dst OR src, 2 gives dst XOR src, 3 gives NOT dst. Each clears carry (bit 0), overflow (bit 11) and auxiliary carry (bit 4).
- R2: Opcode 6 (add) returns dst + src at the selected width. Carry is the carry out of the top bit of that width. Overflow is set when both operands have the same sign and the result's sign differs. Auxiliary carry is bit 4 of dst XOR src XOR result.
- R3: Opcode 7 (subtract) returns dst - src at the width. Carry is set when dst < src as unsigned values. Overflow is set when the operands' signs differ and the result's sign differs from dst. Auxiliary carry is computed as in R2.
- R4: Opcode 11 (compare) produces exactly the status word of R3 for the same operands, and its write enable is 0. All the other listed opcodes drive write enable to 1.
- R5: Opcode 8 (increment) returns dst + 1 and opcode 9 (decrement) returns dst - 1. Both update overflow, auxiliary, zero, sign and parity as for add and subtract, and carry (bit 0) copies the incoming status word's bit 0.
- R6: Opcode 10 (negate) returns 0 - dst at the width. Carry is set exactly when the masked dst is nonzero. Overflow and auxiliary carry follow the subtract rules with 0 as the minuend.
- R7: Opcode 4 (shift left) and opcode 5 (arithmetic shift right) shift dst by src[4:0]. The right shift fills with the width's sign bit. Carry is the last bit shifted out: 0 once a left shift has moved everything out, and the sign once a right shift has. Left-shift overflow is the result's top bit XOR the new carry, right-shift overflow is 0, and auxiliary carry is 0 for both.
- R8: A shift with src[4:0] equal to 0 returns dst unchanged at the width, with write enable 1. The status word equals the incoming one except for the fixed bits of R10.
- R9: Width code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the width are ignored and result bits above it are 0. Zero (bit 6) is set when the result is 0 at the width. Sign (bit 7) is the top result bit at the width. Parity (bit 2) is set when result bits 7:0 hold an even number of ones.
- R10: The output status word always has bit 1 = 1 and bits 3 and 5 = 0. All bits other than 0, 2, 4, 6, 7 and 11 copy the incoming status word.
- R11: After reset, outValid, result and writeEn are 0 and flagsOut is 0x00000002. Each cycle with inValid high gives outValid high with that operation's outputs one clock edge later. A cycle with inValid low gives outValid low one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation present this cycle |
| opcode | input | 4 | Operation code (see R1 to R8) |
| widthSel | input | 2 | Operand width code (see R9) |
| srcOp | input | 32 | Source operand, or shift count in bits 4:0 |
| dstOp | input | 32 | Destination operand |
| flagsIn | input | 32 | Current status word |
| outValid | output | 1 | Registered outputs hold a new operation |
| result | output | 32 | Result at the width, zero-extended |
| writeEn | output | 1 | Destination should be written |
| flagsOut | output | 32 | New status word |

## Verification
The stimulus aims at width boundaries: byte and word sums that carry or overflow exactly at bit 7 or bit 15, garbage in the operand bits above the width, and width code 3. A design that masked at the wrong width would show the wrong carry, sign or zero flag there. Shift counts of 0, of exactly the width and of more than the width are driven, because a wrong count rule corrupts the shifted-out carry or clobbers flags that must be kept. Increment and decrement are run with the incoming carry set and clear, negate is run on 0 and on the most negative value, and compare is checked for a stray write enable. Random vectors with busy incoming status words catch lost pass-through bits or a broken fixed bit.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 32;
  localparam int FLAG_W = 32;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int IDX_W  = $clog2(DATA_W);

  localparam int CF_BIT = 0;
  localparam int ONE_BIT = 1;
  localparam int PF_BIT = 2;
  localparam int RSV3_BIT = 3;
  localparam int AF_BIT = 4;
  localparam int RSV5_BIT = 5;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int OF_BIT = 11;

  localparam logic [FLAG_W-1:0] FLAG_RESET = FLAG_W'(1) << ONE_BIT;

  typedef enum logic [3:0] {
    OP_AND = 4'd0, OP_OR = 4'd1, OP_XOR = 4'd2, OP_NOT = 4'd3,
    OP_SHL = 4'd4, OP_SAR = 4'd5, OP_ADD = 4'd6, OP_SUB = 4'd7,
    OP_INC = 4'd8, OP_DEC = 4'd9, OP_NEG = 4'd10, OP_CMP = 4'd11
  } opcode_e;

  typedef enum logic [1:0] { B_SRC = 2'd0, B_ONE = 2'd1, B_DST = 2'd2 } bsel_e;

  typedef struct packed {
    logic       writeDst;
    logic       updFlags;
    logic       subtract;
    logic       zeroA;
    bsel_e      bSel;
    logic       keepCarry;
    logic       selLogic;
    logic [1:0] logicFn;
    logic       selShift;
    logic       shiftRight;
  } ctl_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opcode,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    ctl.bSel = B_SRC;
    case (opcode)
      OP_AND, OP_OR, OP_XOR, OP_NOT: begin
        ctl.writeDst = 1'b1;
        ctl.updFlags = 1'b1;
        ctl.selLogic = 1'b1;
        ctl.logicFn  = opcode[1:0];
      end
      OP_SHL, OP_SAR: begin
        ctl.writeDst   = 1'b1;
        ctl.updFlags   = 1'b1;
        ctl.selShift   = 1'b1;
        ctl.shiftRight = (opcode == OP_SAR);
      end
      OP_ADD: begin
        ctl.writeDst = 1'b1;
        ctl.updFlags = 1'b1;
      end
      OP_SUB, OP_CMP: begin
        ctl.writeDst = (opcode == OP_SUB);
        ctl.updFlags = 1'b1;
        ctl.subtract = 1'b1;
      end
      OP_INC, OP_DEC: begin
        ctl.writeDst  = 1'b1;
        ctl.updFlags  = 1'b1;
        ctl.subtract  = (opcode == OP_DEC);
        ctl.bSel      = B_ONE;
        ctl.keepCarry = 1'b1;
      end
      OP_NEG: begin
        ctl.writeDst = 1'b1;
        ctl.updFlags = 1'b1;
        ctl.subtract = 1'b1;
        ctl.zeroA    = 1'b1;
        ctl.bSel     = B_DST;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
(
  input  ctl_t              ctl,
  input  logic [1:0]        widthSel,
  input  logic [DATA_W-1:0] srcOp,
  input  logic [DATA_W-1:0] dstOp,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsNew
);
  logic [DATA_W-1:0] wMask;
  logic [IDX_W-1:0]  msbIdx;
  logic [IDX_W:0]    topIdx;

  always_comb begin
    case (widthSel)
      2'd0: begin wMask = {{(DATA_W-8){1'b0}}, 8'hFF};    msbIdx = IDX_W'(7);  end
      2'd1: begin wMask = {{(DATA_W-16){1'b0}}, 16'hFFFF}; msbIdx = IDX_W'(15); end
      default: begin wMask = '1; msbIdx = IDX_W'(DATA_W-1); end
    endcase
  end
  assign topIdx = {1'b0, msbIdx} + 1'b1;

  logic [DATA_W-1:0] dstM, srcM, opA, opB;
  assign dstM = dstOp & wMask;
  assign srcM = srcOp & wMask;
  assign opA  = ctl.zeroA ? '0 : dstM;

  always_comb begin
    case (ctl.bSel)
      B_ONE:   opB = DATA_W'(1);
      B_DST:   opB = dstM;
      default: opB = srcM;
    endcase
  end

  // Adder path
  logic [DATA_W:0]   sumExt;
  logic [DATA_W-1:0] addRes;
  logic addCarry, addOvf, addAux, aSign, bSign, rSign;
  assign sumExt   = ctl.subtract ? ({1'b0, opA} - {1'b0, opB}) : ({1'b0, opA} + {1'b0, opB});
  assign addRes   = sumExt[DATA_W-1:0] & wMask;
  assign addCarry = ctl.subtract ? (opA < opB) : sumExt[topIdx];
  assign aSign    = opA[msbIdx];
  assign bSign    = opB[msbIdx];
  assign rSign    = addRes[msbIdx];
  assign addOvf   = ctl.subtract ? ((aSign != bSign) && (rSign != aSign))
                                 : ((aSign == bSign) && (rSign != aSign));
  assign addAux   = opA[4] ^ opB[4] ^ addRes[4];

  // Logic path
  logic [DATA_W-1:0] logicRes;
  always_comb begin
    case (ctl.logicFn)
      2'd0:    logicRes = dstM & srcM;
      2'd1:    logicRes = dstM | srcM;
      2'd2:    logicRes = dstM ^ srcM;
      default: logicRes = ~dstM & wMask;
    endcase
  end

  // Shift path
  logic [CNT_W-1:0]    shCnt, cntM1;
  logic [DATA_W-1:0]   dstSx, sarRes, shlRes, shRes;
  logic [2*DATA_W-1:0] shlFull;
  logic shCarry, shOvf, shlCarry;
  assign shCnt    = srcOp[CNT_W-1:0];
  assign cntM1    = shCnt - 1'b1;
  assign dstSx    = dstM | (dstM[msbIdx] ? ~wMask : '0);
  assign sarRes   = DATA_W'($signed(dstSx) >>> shCnt) & wMask;
  assign shlFull  = {{DATA_W{1'b0}}, dstM} << shCnt;
  assign shlRes   = shlFull[DATA_W-1:0] & wMask;
  assign shlCarry = shlFull[topIdx];
  assign shRes    = ctl.shiftRight ? sarRes : shlRes;
  assign shCarry  = ctl.shiftRight ? dstSx[cntM1] : shlCarry;
  assign shOvf    = ctl.shiftRight ? 1'b0 : (shlRes[msbIdx] ^ shlCarry);

  assign result = ctl.selShift ? shRes : (ctl.selLogic ? logicRes : addRes);

  always_comb begin
    flagsNew = flagsIn;
    if (ctl.updFlags && !(ctl.selShift && shCnt == '0)) begin
      flagsNew[PF_BIT] = ~^result[7:0];
      flagsNew[ZF_BIT] = (result == '0);
      flagsNew[SF_BIT] = result[msbIdx];
      if (ctl.selLogic) begin
        flagsNew[CF_BIT] = 1'b0;
        flagsNew[OF_BIT] = 1'b0;
        flagsNew[AF_BIT] = 1'b0;
      end else if (ctl.selShift) begin
        flagsNew[CF_BIT] = shCarry;
        flagsNew[OF_BIT] = shOvf;
        flagsNew[AF_BIT] = 1'b0;
      end else begin
        flagsNew[CF_BIT] = ctl.keepCarry ? flagsIn[CF_BIT] : addCarry;
        flagsNew[OF_BIT] = addOvf;
        flagsNew[AF_BIT] = addAux;
      end
    end
    flagsNew[ONE_BIT]  = 1'b1;
    flagsNew[RSV3_BIT] = 1'b0;
    flagsNew[RSV5_BIT] = 1'b0;
  end
endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        opcode,
  input  logic [1:0]        widthSel,
  input  logic [DATA_W-1:0] srcOp,
  input  logic [DATA_W-1:0] dstOp,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [FLAG_W-1:0] flagsOut
);
  ctl_t              ctl;
  logic [DATA_W-1:0] resNext;
  logic [FLAG_W-1:0] flagsNext;

  alu_ctrl u_ctrl (.opcode(opcode), .ctl(ctl));

  alu_datapath u_dp (
    .ctl(ctl), .widthSel(widthSel), .srcOp(srcOp), .dstOp(dstOp),
    .flagsIn(flagsIn), .result(resNext), .flagsNew(flagsNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      writeEn  <= 1'b0;
      flagsOut <= FLAG_RESET;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result   <= resNext;
        writeEn  <= ctl.writeDst;
        flagsOut <= flagsNext;
      end
    end
  end

  p_fixed_bits_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagsOut[ONE_BIT] && !flagsOut[RSV3_BIT] && !flagsOut[RSV5_BIT]);

  p_cmp_nowrite_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == OP_CMP) |=> (outValid && !writeEn));

  p_keep_carry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opcode == OP_INC || opcode == OP_DEC))
      |=> (flagsOut[CF_BIT] == $past(flagsIn[CF_BIT])));

  p_logic_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode <= OP_NOT) |=> (!flagsOut[CF_BIT] && !flagsOut[OF_BIT]));

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode >= OP_ADD && opcode <= OP_CMP)
      |=> (flagsOut[ZF_BIT] == (result == '0)));

  p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_valid_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_shift0_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opcode == OP_SHL || opcode == OP_SAR) && srcOp[CNT_W-1:0] == '0)
      |=> (flagsOut[OF_BIT] == $past(flagsIn[OF_BIT]) &&
           flagsOut[CF_BIT] == $past(flagsIn[CF_BIT])));
endmodule

// File: tb/tb_alu_top.sv
module tb_alu_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [1:0]  widthSel = '0;
  logic [31:0] srcOp = '0, dstOp = '0, flagsIn = '0;
  logic        outValid, writeEn;
  logic [31:0] result, flagsOut;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [31:0] res;
    logic        we;
    logic [31:0] flg;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  alu_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .widthSel(widthSel), .srcOp(srcOp), .dstOp(dstOp), .flagsIn(flagsIn),
    .outValid(outValid), .result(result), .writeEn(writeEn), .flagsOut(flagsOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic exp_t model(input logic [3:0] op, input logic [1:0] ws,
                                 input logic [31:0] s, input logic [31:0] d,
                                 input logic [31:0] fin);
    exp_t e;
    int w;
    longint unsigned m, dm, sm, sb, t, r;
    longint sx;
    int c;
    logic cf, of, af, upd;
    w  = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
    m  = (64'd1 << w) - 1;
    dm = {32'd0, d} & m;
    sm = {32'd0, s} & m;
    sb = 64'd1 << (w - 1);
    c  = int'(s[4:0]);
    cf = fin[0]; of = fin[11]; af = fin[4]; upd = 1'b1; r = 0;
    e.tag = "R1";
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3: begin
        r = (op == 0) ? (dm & sm) : (op == 1) ? (dm | sm) : (op == 2) ? (dm ^ sm) : (~dm & m);
        cf = 0; of = 0; af = 0;
      end
      4'd6, 4'd8: begin
        if (op == 4'd8) sm = 1;
        t = dm + sm; r = t & m;
        if (op == 4'd6) cf = ((t >> w) & 1) != 0;
        of = ((dm & sb) == (sm & sb)) && ((r & sb) != (dm & sb));
        af = (((dm ^ sm ^ r) >> 4) & 1) != 0;
        e.tag = (op == 4'd6) ? "R2" : "R5";
      end
      4'd7, 4'd11, 4'd9: begin
        if (op == 4'd9) sm = 1;
        t = dm - sm; r = t & m;
        if (op != 4'd9) cf = dm < sm;
        of = ((dm & sb) != (sm & sb)) && ((r & sb) != (dm & sb));
        af = (((dm ^ sm ^ r) >> 4) & 1) != 0;
        e.tag = (op == 4'd7) ? "R3" : (op == 4'd11) ? "R4" : "R5";
      end
      4'd10: begin
        r = (64'd0 - dm) & m;
        cf = dm != 0;
        of = ((dm & sb) != 0) && ((r & sb) != 0);
        af = (((dm ^ r) >> 4) & 1) != 0;
        e.tag = "R6";
      end
      4'd4: begin
        e.tag = "R7";
        if (c == 0) begin r = dm; upd = 0; e.tag = "R8"; end
        else begin
          t = dm << c; r = t & m;
          cf = ((t >> w) & 1) != 0;
          of = (((r >> (w - 1)) & 1) != 0) ^ cf;
          af = 0;
        end
      end
      4'd5: begin
        e.tag = "R7";
        if (c == 0) begin r = dm; upd = 0; e.tag = "R8"; end
        else begin
          sx = ((dm & sb) != 0) ? longint'(dm | ~m) : longint'(dm);
          r = longint'(sx >>> c) & m;
          cf = ((sx >>> (c - 1)) & 1) != 0;
          of = 0; af = 0;
        end
      end
      default: begin r = 0; upd = 0; end
    endcase
    e.res = r[31:0];
    e.we  = (op != 4'd11);
    e.flg = fin;
    if (upd) begin
      e.flg[0]  = cf;
      e.flg[2]  = ~^r[7:0];
      e.flg[4]  = af;
      e.flg[6]  = (r == 0);
      e.flg[7]  = ((r >> (w - 1)) & 1) != 0;
      e.flg[11] = of;
    end
    e.flg[1] = 1'b1; e.flg[3] = 1'b0; e.flg[5] = 1'b0;
    return e;
  endfunction

  task automatic apply(input logic [3:0] op, input logic [1:0] ws,
                       input logic [31:0] s, input logic [31:0] d, input logic [31:0] f);
    @(negedge clk);
    inValid = 1'b1; opcode = op; widthSel = ws; srcOp = s; dstOp = d; flagsIn = f;
    expQ.push_back(model(op, ws, s, d, f));
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    srcOp = 32'hDEAD_BEEF;
  endtask

  always @(negedge clk) begin
    if (rstN && outValid) begin
      exp_t e;
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 outValid: got 1 expected 0");
      end else begin
        e = expQ.pop_front();
        check(e.tag, "result", result, e.res);
        check(e.we ? "R11" : "R4", "writeEn", {31'd0, writeEn}, {31'd0, e.we});
        check({e.tag, " R9 R10"}, "flags", flagsOut, e.flg);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "reset outValid", {31'd0, outValid}, 32'd0);
    check("R11", "reset result", result, 32'd0);
    check("R11", "reset writeEn", {31'd0, writeEn}, 32'd0);
    check("R11", "reset flags", flagsOut, 32'h2);
    rstN = 1'b1;

    apply(4'd0, 2'd0, 32'hFFFF_FF0F, 32'hABCD_12F3, 32'h0000_0801); // R1 upper garbage
    apply(4'd3, 2'd1, 32'h0, 32'h1234_00FF, 32'hFFFF_FFFF);        // R1, R10 pass-through
    apply(4'd6, 2'd0, 32'h01, 32'h7F, 32'h0);                       // R2 byte overflow
    apply(4'd6, 2'd0, 32'h01, 32'hFF, 32'h0);                       // R2 byte carry, zero
    apply(4'd6, 2'd1, 32'h8000, 32'h8000, 32'h0);                   // R2 word carry+ovf
    apply(4'd7, 2'd1, 32'h1, 32'h0, 32'h0);                         // R3 borrow
    apply(4'd11, 2'd2, 32'h55, 32'h55, 32'h0);                      // R4 equal
    apply(4'd8, 2'd0, 32'h0, 32'hFF, 32'h1);                        // R5 carry kept set
    apply(4'd9, 2'd0, 32'h0, 32'h00, 32'h0);                        // R5 carry kept clear
    apply(4'd10, 2'd0, 32'h0, 32'h0, 32'h1);                        // R6 zero
    apply(4'd10, 2'd0, 32'h0, 32'h80, 32'h0);                       // R6 most negative
    apply(4'd4, 2'd0, 32'h20, 32'h81, 32'h0000_0895);               // R8 count masks to 0
    apply(4'd5, 2'd1, 32'h0, 32'h8001, 32'h0);                      // R8
    apply(4'd4, 2'd0, 32'h8, 32'h81, 32'h0);                        // R7 count == width
    apply(4'd4, 2'd0, 32'h9, 32'hFF, 32'h0);                        // R7 count > width
    apply(4'd5, 2'd0, 32'h3, 32'h80, 32'h0);                        // R7 sign fill
    apply(4'd5, 2'd0, 32'h1F, 32'h90, 32'h0);                       // R7 far right
    apply(4'd6, 2'd3, 32'hFFFF_FFFF, 32'h1, 32'h0);                 // R9 width 3
    idle();
    idle();

    for (int i = 0; i < 1500; i++) begin
      logic [3:0] op;
      logic [31:0] s;
      op = 4'($urandom_range(0, 11));
      s  = $urandom;
      if ((op == 4'd4 || op == 4'd5) && ($urandom_range(0, 3) == 0)) s[4:0] = 5'd0;
      if ($urandom_range(0, 7) == 0) s = 32'h0;
      apply(op, 2'($urandom_range(0, 3)), s, $urandom, $urandom);
      if ($urandom_range(0, 5) == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    check("R11", "queue drained", 32'(expQ.size()), 32'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule